// File: doc/BRIEF.md
# Fractional Clock Divider

This block derives a slower clock-enable from a fast input clock by dividing by a ratio that need not be a whole number. The ratio is a whole part plus a 20-bit binary fraction. Each output period lasts either the whole part or one cycle more. A first-order phase accumulator chooses between the two, so that over a long run the average period equals the programmed ratio to within 2^-20 of one input cycle.

A host presents a new ratio on the ratio inputs and pulses a load strobe. The divider keeps the ratio it is using until the current output period ends, then switches. A ratio that does not exceed two is replaced by the smallest legal ratio, and an error flag stays high until a legal ratio is loaded. The enable output is meant to gate downstream logic that runs on the same fast clock.

Top module: `frac_clk_div`

## Requirements
- R1: The ratio is `div_int` (8 bits, unsigned) plus `div_frac`/2^20. Bit 19 of `div_frac` is worth 1/2, bit 18 is worth 1/4, and so on down to bit 0, which is worth 2^-20.
- R2: `clk_en` is high for single cycles only. The distance between two consecutive pulses is always either N or N+1 cycles, where N is the whole part in use.
- R3: A 20-bit accumulator, cleared by reset, adds the fraction once at the start of each period. That period lasts N+1 cycles when the addition carries out of 20 bits, and N cycles otherwise. With N=4 and fraction 0x40000 after reset, the first four gaps are 4, 4, 4, 5.
- R4: Over any 2^20 consecutive periods the total is N·2^20 + F cycles. The same holds for a fraction that is a multiple of 2^(20-k) over 2^k periods: N·2^k + F/2^(20-k) cycles. For example, N=5 and F=0x30000 give 83 cycles over 16 periods.
- R5: A loaded ratio with whole part below 2, or with whole part 2 and fraction 0, is replaced by 2 + 2^-20. `cfg_err` goes high on the clock edge that captures that load. A load of a legal ratio clears `cfg_err` on its capturing edge.
- R6: A ratio loaded in the middle of a period takes effect only when the current period ends. If several loads arrive before that point, the last one wins.
- R7: While `rst` is high, `clk_en` and `cfg_err` are low, the accumulator and the period counter are cleared, and the ratio on the inputs (corrected as in R5) becomes the active one. The first pulse comes on the first clock edge after `rst` falls.
- R8: A load strobe in the final cycle of a period applies its ratio to the very next period. The pending value it would otherwise have produced is not used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| div_int | input | 8 | Whole part of the ratio |
| div_frac | input | 20 | Binary fraction of the ratio, MSB worth 1/2 |
| load | input | 1 | Strobe that captures `div_int` and `div_frac` |
| clk_en | output | 1 | One-cycle enable pulse, once per output period |
| cfg_err | output | 1 | High while the last loaded ratio was illegal and got corrected |

## Verification
The case that matters most is a load that arrives in the very cycle a period ends. Two things then happen in one cycle: the period boundary reads the active ratio, and the pending register is written. The bench uses its own cycle model to find that exact cycle, drives the load into it, and checks that the next gap already follows the new whole part. It also checks that the accumulator carry is taken with the new fraction. Mid-period loads and back-to-back loads are checked as well: the gap in progress must keep the old length, and only the last load may shape the gap after it.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

    localparam int DIV_INT_W = 8;
    localparam int FRAC_W    = 20;

    typedef struct packed {
        logic [DIV_INT_W-1:0] whole;
        logic [FRAC_W-1:0]    part;
    } ratio_t;

    function automatic logic ratio_bad(ratio_t r);
        return (r.whole < DIV_INT_W'(2)) ||
               ((r.whole == DIV_INT_W'(2)) && (r.part == '0));
    endfunction

    function automatic ratio_t ratio_fix(ratio_t r);
        ratio_t o;
        o = r;
        if (ratio_bad(r)) begin
            o.whole = DIV_INT_W'(2);
            o.part  = FRAC_W'(1);
        end
        return o;
    endfunction

endpackage

// File: rtl/fd_ratio_stage.sv
module fd_ratio_stage
    import frac_div_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ratio_t req_i,
    input  logic   load_i,
    input  logic   boundary_i,
    output ratio_t use_o,
    output logic   err_o
);
    ratio_t act_q;
    ratio_t pend_q;
    logic   pend_vld_q;
    logic   err_q;
    ratio_t req_fixed;

    assign req_fixed = ratio_fix(req_i);

    // A strobe in the closing cycle of a period bypasses the pending slot.
    always_comb begin
        if (load_i)
            use_o = req_fixed;
        else if (pend_vld_q)
            use_o = pend_q;
        else
            use_o = act_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q      <= req_fixed;
            pend_q     <= req_fixed;
            pend_vld_q <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            if (boundary_i) begin
                act_q      <= use_o;
                pend_vld_q <= 1'b0;
            end else if (load_i) begin
                pend_q     <= req_fixed;
                pend_vld_q <= 1'b1;
            end
            if (load_i)
                err_q <= ratio_bad(req_i);
        end
    end

    assign err_o = err_q;

endmodule

// File: rtl/fd_phase_acc.sv
module fd_phase_acc #(
    parameter int FRAC_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FRAC_W-1:0] step_i,
    input  logic              boundary_i,
    output logic              carry_o,
    output logic [FRAC_W-1:0] acc_o
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    assign sum     = {1'b0, acc_q} + {1'b0, step_i};
    assign carry_o = sum[FRAC_W];

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (boundary_i)
            acc_q <= sum[FRAC_W-1:0];
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/fd_period_cnt.sv
module fd_period_cnt #(
    parameter int INT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [INT_W-1:0] whole_i,
    input  logic             carry_i,
    output logic             boundary_o,
    output logic             tick_o
);
    localparam int EXT_W = INT_W + 1;

    logic [INT_W-1:0] cnt_q;
    logic [EXT_W-1:0] reload;
    logic             tick_q;

    assign boundary_o = (cnt_q == '0);
    // Cycles left after this one: N - 1, or N when stretched.
    assign reload = {1'b0, whole_i} + EXT_W'(carry_i) - EXT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= boundary_o;
            if (boundary_o)
                cnt_q <= reload[INT_W-1:0];
            else
                cnt_q <= cnt_q - INT_W'(1);
        end
    end

    assign tick_o = tick_q;

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
    import frac_div_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DIV_INT_W-1:0] div_int,
    input  logic [FRAC_W-1:0]    div_frac,
    input  logic                 load,
    output logic                 clk_en,
    output logic                 cfg_err
);
    ratio_t            req;
    ratio_t            use_ratio;
    logic              period_edge;
    logic              stretch;
    logic [FRAC_W-1:0] acc_val;

    assign req.whole = div_int;
    assign req.part  = div_frac;

    fd_ratio_stage u_ratio (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .load_i     (load),
        .boundary_i (period_edge),
        .use_o      (use_ratio),
        .err_o      (cfg_err)
    );

    fd_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .step_i     (use_ratio.part),
        .boundary_i (period_edge),
        .carry_o    (stretch),
        .acc_o      (acc_val)
    );

    fd_period_cnt #(.INT_W(DIV_INT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .whole_i    (use_ratio.whole),
        .carry_i    (stretch),
        .boundary_o (period_edge),
        .tick_o     (clk_en)
    );

endmodule

// File: rtl/frac_div_checker.sv
module frac_div_checker #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic [INT_W-1:0]  div_int,
    input logic [FRAC_W-1:0] div_frac,
    input logic              load,
    input logic              clk_en,
    input logic              cfg_err,
    input logic              boundary,
    input logic [FRAC_W-1:0] acc
);
    logic bad_req;
    logic rst_d;

    assign bad_req = (div_int < INT_W'(2)) ||
                     ((div_int == INT_W'(2)) && (div_frac == '0));

    always_ff @(posedge clk) rst_d <= rst;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        clk_en |=> !clk_en);                                     // R2
    AST_PULSE_AFTER_EDGE: assert property (@(posedge clk) disable iff (rst)
        boundary |=> clk_en);                                    // R2
    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(acc));                             // R3
    AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
        (load && bad_req) |=> cfg_err);                          // R5
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (load && !bad_req) |=> !cfg_err);                        // R5

    always @(negedge clk) begin
        if (rst_d === 1'b1)
            AST_RST_QUIET: assert (!clk_en && !cfg_err);         // R7
    end

endmodule

bind frac_clk_div frac_div_checker #(
    .INT_W  (frac_div_pkg::DIV_INT_W),
    .FRAC_W (frac_div_pkg::FRAC_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .div_int  (div_int),
    .div_frac (div_frac),
    .load     (load),
    .clk_en   (clk_en),
    .cfg_err  (cfg_err),
    .boundary (period_edge),
    .acc      (acc_val)
);

// File: tb/frac_clk_div_tb.sv
`timescale 1ns/1ps
module frac_clk_div_tb;
    localparam int ONE = 1 << 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  div_int = 8'd4;
    logic [19:0] div_frac = 20'h40000;
    logic        load = 1'b0;
    logic        clk_en;
    logic        cfg_err;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    frac_clk_div u_dut (
        .clk(clk), .rst(rst), .div_int(div_int), .div_frac(div_frac),
        .load(load), .clk_en(clk_en), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: cycles left in the period, phase, ratios.
    int  m_left, m_n, m_f, m_pn, m_pf, m_un, m_uf;
    bit  m_pv, m_en, m_err;
    longint m_acc, m_sum;

    function automatic bit is_bad(input int n, input int f);
        return (n < 2) || (n == 2 && f == 0);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_n = is_bad(div_int, div_frac) ? 2 : int'(div_int);
            m_f = is_bad(div_int, div_frac) ? 1 : int'(div_frac);
            m_pv = 0; m_left = 0; m_acc = 0; m_en = 0; m_err = 0;
        end else begin
            if (load) begin
                m_un = is_bad(div_int, div_frac) ? 2 : int'(div_int);
                m_uf = is_bad(div_int, div_frac) ? 1 : int'(div_frac);
            end else if (m_pv) begin
                m_un = m_pn; m_uf = m_pf;
            end else begin
                m_un = m_n; m_uf = m_f;
            end
            m_en = (m_left == 0);
            if (m_en) begin
                m_n = m_un; m_f = m_uf; m_pv = 0;
                m_sum = m_acc + m_uf;
                m_acc = m_sum % ONE;
                m_left = m_un + ((m_sum >= ONE) ? 1 : 0) - 1;
            end else begin
                m_left--;
                if (load) begin m_pn = m_un; m_pf = m_uf; m_pv = 1; end
            end
            if (load) m_err = is_bad(div_int, div_frac);
        end
    end

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        chk(clk_en === m_en, "R2 clk_en vs model", clk_en, m_en);
        chk(cfg_err === m_err, "R5 cfg_err vs model", cfg_err, m_err);
    end

    task automatic wait_pulse();
        do @(negedge clk); while (clk_en !== 1'b1);
    endtask

    task automatic gap(output int g);
        g = 0;
        do begin @(negedge clk); g++; end while (clk_en !== 1'b1);
    endtask

    task automatic do_load(input int n, input int f);
        div_int = 8'(n); div_frac = 20'(f); load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic apply(input int n, input int f);
        do_load(n, f);
        wait_pulse();
        wait_pulse();
    endtask

    int g, tot;

    initial begin
        // R7: reset state
        repeat (3) @(negedge clk);
        chk(clk_en === 1'b0, "R7 clk_en in reset", clk_en, 0);
        chk(cfg_err === 1'b0, "R7 cfg_err in reset", cfg_err, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(clk_en === 1'b1, "R7 first pulse after release", clk_en, 1);

        // R3: accumulator from zero, N=4, F=1/4
        gap(g); chk(g == 4, "R3 gap1", g, 4);
        gap(g); chk(g == 4, "R3 gap2", g, 4);
        gap(g); chk(g == 4, "R3 gap3", g, 4);
        gap(g); chk(g == 5, "R3 gap4 stretched", g, 5);

        // R2: whole ratio
        apply(6, 0);
        for (int i = 0; i < 3; i++) begin
            gap(g); chk(g == 6, "R2 integer gap", g, 6);
        end

        // R1: fraction MSB is one half
        apply(3, 20'h80000);
        tot = 0;
        for (int i = 0; i < 4; i++) begin
            gap(g); chk(g == 3 || g == 4, "R1 gap in {N,N+1}", g, 3); tot += g;
        end
        chk(tot == 14, "R1 half fraction over 4 periods", tot, 14);

        // R4: N=5, F=3/16 over 16 periods
        apply(5, 20'h30000);
        tot = 0;
        for (int i = 0; i < 16; i++) begin gap(g); tot += g; end
        chk(tot == 83, "R4 total over 16 periods", tot, 83);

        // R5: illegal ratios corrected and flagged
        do_load(1, 20'h80000);
        chk(cfg_err === 1'b1, "R5 flag on whole<2", cfg_err, 1);
        wait_pulse(); wait_pulse();
        gap(g); chk(g == 2, "R5 clamped gap", g, 2);
        do_load(2, 0);
        chk(cfg_err === 1'b1, "R5 flag on exactly 2", cfg_err, 1);
        do_load(2, 20'h40000);
        chk(cfg_err === 1'b0, "R5 flag cleared", cfg_err, 0);
        wait_pulse(); wait_pulse();
        tot = 0;
        for (int i = 0; i < 4; i++) begin gap(g); tot += g; end
        chk(tot == 9, "R5 legal 2.25 over 4 periods", tot, 9);

        // R6: mid-period loads wait for the boundary; last one wins
        apply(6, 0);
        do_load(9, 0);
        do_load(3, 0);
        g = 2;
        do begin @(negedge clk); g++; end while (clk_en !== 1'b1);
        chk(g == 6, "R6 running period keeps old N", g, 6);
        gap(g); chk(g == 3, "R6 last load wins", g, 3);

        // R8: load in the closing cycle of a period
        apply(5, 0);
        while (m_left != 0) @(negedge clk);
        do_load(7, 20'h80000);
        chk(clk_en === 1'b1, "R8 boundary pulse", clk_en, 1);
        gap(g); chk(g == 7, "R8 new N next period", g, 7);
        gap(g); chk(g == 8, "R8 new fraction carries", g, 8);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule